// File: doc/BRIEF.md
# Audio Sample Channel FIFO

This block is a single buffered channel for 32-bit audio sample words, placed between a converter-side port and a processor-side port. A parameter sets the direction. For capture, the converter pushes samples and the processor pops them. For playback, the processor pushes samples and the converter drains them. Both sides use a valid/ready handshake. Storage is a 512-entry memory written so that block RAM can be inferred.

Around the storage the block produces the state that a register decoder and an interrupt combiner further up the chip consume:
- the raw read and write indices, packed into one status word;
- real full and real empty flags;
- almost-full and almost-empty flags, each compared against a 9-bit threshold taken from one packed configuration word;
- a byte count of room, whose meaning depends on direction;
- a one-cycle overflow pulse.

A clear input resets both indices at once while the channel keeps running.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset the read and write indices are 0, `pop_valid` is 0 and `push_ready` is 1. `fifo_status` is 4'b1010, meaning empty and almost-empty are set, provided the almost-full threshold is nonzero. `avail_bytes` is 0 for capture and 2048 for playback.
- R2: Words leave on the pop side in the order they were accepted on the push side, with their 32-bit values unchanged. The head word is visible on `pop_data` whenever `pop_valid` is 1, including in the cycle right after it was pushed into an empty channel.
- R3: A push offered while the channel holds 512 words is not stored and leaves the write index unchanged. In the next cycle `overflow` is 1. It returns to 0 once no push is offered against a full channel.
- R4: `fifo_status` bit 0 is real-full (512 words) and bit 1 is real-empty (0 words). `push_ready` is 0 exactly when full or clearing. Both flags change in the cycle after the handshake that changes the fill level.
- R5: `fifo_status` bit 2 (almost-full) is 1 when the fill level is at least the threshold in `thr_cfg` bits 8:0. A threshold change shows one cycle later.
- R6: `fifo_status` bit 3 (almost-empty) is 1 when the fill level is at most the threshold in `thr_cfg` bits 24:16.
- R7: `addr_word` bits 25:16 carry the read index and bits 9:0 carry the write index. Each index counts accepted pops or pushes modulo 512 in the low 9 bits of its field. All other bits are 0.
- R8: For capture, `avail_bytes` is the number of bytes that can be read. With write index w and read index r, it is 4×(w−r) when w≥r and 4×(512−r+w) when w<r. It is 2048 when full.
- R9: For playback, `avail_bytes` is the number of bytes that can be written. It is 4×(512−w+r) when w≥r and 4×(r−w) when w<r. It is 0 when full.
- R10: A cycle with `clear` high empties the channel: both indices become 0 and the flags show empty on the next cycle. Clear wins over a push or pop offered in the same cycle; neither takes effect.
- R11: A push and a pop accepted in the same cycle leave the fill level unchanged and advance both indices by one.
- R12: A pop offered while empty is not accepted: `pop_valid` stays 0 and the read index is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | One-cycle command that empties the channel |
| thr_cfg | input | 32 | Packed thresholds: almost-empty in 24:16, almost-full in 8:0 |
| push_valid | input | 1 | Producer offers a word |
| push_ready | output | 1 | Channel can accept a word this cycle |
| push_data | input | 32 | Word offered by the producer |
| pop_valid | output | 1 | A word is available to the consumer |
| pop_ready | input | 1 | Consumer takes the head word |
| pop_data | output | 32 | Head word |
| addr_word | output | 32 | Read index in 25:16, write index in 9:0 |
| fifo_status | output | 4 | {almost-empty, almost-full, empty, full} |
| avail_bytes | output | 12 | Readable bytes (capture) or writable bytes (playback) |
| overflow | output | 1 | One-cycle pulse after a push refused while full |

## Verification
Several properties are checked on every cycle:
- full and empty are never set together;
- `pop_valid` always agrees with the empty flag;
- `push_ready` is high whenever the channel is neither full nor clearing;
- an overflow pulse only follows a push that was offered against a full channel;
- a refused push leaves the write index alone;
- a clear always leaves zeroed indices and an empty channel.

The following can only be shown by the directed scenarios:
- data ordering across the read-during-write hazard;
- threshold comparisons at their exact boundary levels;
- the two direction-dependent byte formulas, including index wrap and the full case;
- words offered during a clear never reappearing.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  // Bit positions inside the status nibble; the interrupt combiner decodes these.
  localparam int ST_FULL   = 0;
  localparam int ST_EMPTY  = 1;
  localparam int ST_AFULL  = 2;
  localparam int ST_AEMPTY = 3;
  localparam int ST_W      = 4;

  // Field positions in the threshold and index words.
  localparam int AF_LSB = 0;
  localparam int AE_LSB = 16;
  localparam int WR_LSB = 0;
  localparam int RD_LSB = 16;
endpackage

// File: rtl/afifo_ptr_ctl.sv
module afifo_ptr_ctl #(
  parameter  int AW = 9,
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push_valid,
  input  logic          pop_ready,
  output logic          push_ready,
  output logic          pop_valid,
  output logic          push_fire,
  output logic          overflow,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic [AW-1:0] rd_idx_nxt,
  output logic [LW-1:0] level_nxt
);
  localparam logic [LW-1:0] FULL_LVL = LW'(2 ** AW);

  logic [LW-1:0] level;
  logic          full;
  logic          pop_fire;
  logic [AW-1:0] wr_idx_nxt;

  assign full       = (level == FULL_LVL);
  assign push_ready = !full && !clear;
  assign pop_valid  = (level != '0);
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_valid && pop_ready && !clear;

  // Clear outranks both handshakes.
  always_comb begin
    if (clear) begin
      level_nxt  = '0;
      wr_idx_nxt = '0;
      rd_idx_nxt = '0;
    end else begin
      level_nxt  = level + LW'(push_fire) - LW'(pop_fire);
      wr_idx_nxt = push_fire ? wr_idx + AW'(1) : wr_idx;
      rd_idx_nxt = pop_fire  ? rd_idx + AW'(1) : rd_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level    <= '0;
      wr_idx   <= '0;
      rd_idx   <= '0;
      overflow <= 1'b0;
    end else begin
      level    <= level_nxt;
      wr_idx   <= wr_idx_nxt;
      rd_idx   <= rd_idx_nxt;
      overflow <= push_valid && full && !clear;
    end
  end
endmodule

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter  int DW = 32,
  parameter  int AW = 9,
  localparam int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ram_q;
  logic [DW-1:0] byp_data;
  logic          byp_hit;

  // Plain synchronous-read memory so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ram_q <= mem[raddr];
  end

  // Read-during-write on the same entry: forward the new word.
  always_ff @(posedge clk) begin
    if (rst) byp_hit <= 1'b0;
    else     byp_hit <= we && (waddr == raddr);
  end

  always_ff @(posedge clk) begin
    byp_data <= wdata;
  end

  assign rdata = byp_hit ? byp_data : ram_q;
endmodule

// File: rtl/afifo_flag_gen.sv
module afifo_flag_gen
  import afifo_pkg::*;
#(
  parameter  int AW      = 9,
  parameter  bit CAPTURE = 1'b1,
  localparam int LW      = AW + 1,
  localparam int BW      = AW + 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LW-1:0]   level_nxt,
  input  logic [AW-1:0]   af_thr,
  input  logic [AW-1:0]   ae_thr,
  output logic [ST_W-1:0] status,
  output logic [BW-1:0]   avail_bytes
);
  localparam logic [LW-1:0] FULL_LVL  = LW'(2 ** AW);
  localparam logic [BW-1:0] RST_AVAIL = CAPTURE ? '0 : {FULL_LVL, 2'b00};

  logic [LW-1:0]   room_cnt;
  logic [ST_W-1:0] st_d;

  // Direction picks what the byte count means.
  generate
    if (CAPTURE) begin : g_capture
      assign room_cnt = level_nxt;
    end else begin : g_playback
      assign room_cnt = FULL_LVL - level_nxt;
    end
  endgenerate

  always_comb begin
    st_d            = '0;
    st_d[ST_FULL]   = (level_nxt == FULL_LVL);
    st_d[ST_EMPTY]  = (level_nxt == '0);
    st_d[ST_AFULL]  = (level_nxt >= {1'b0, af_thr});
    st_d[ST_AEMPTY] = (level_nxt <= {1'b0, ae_thr});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status            <= '0;
      status[ST_EMPTY]  <= 1'b1;
      status[ST_AEMPTY] <= 1'b1;
      avail_bytes       <= RST_AVAIL;
    end else begin
      status      <= st_d;
      avail_bytes <= {room_cnt, 2'b00};
    end
  end
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
  import afifo_pkg::*;
#(
  parameter  int DATA_W  = 32,
  parameter  int AW      = 9,
  parameter  int WORD_W  = 32,
  parameter  bit CAPTURE = 1'b1,
  localparam int FW      = AW + 1,
  localparam int LW      = AW + 1,
  localparam int BW      = AW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [WORD_W-1:0] thr_cfg,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [DATA_W-1:0] pop_data,
  output logic [WORD_W-1:0] addr_word,
  output logic [ST_W-1:0]   fifo_status,
  output logic [BW-1:0]     avail_bytes,
  output logic              overflow
);
  logic          push_fire;
  logic [AW-1:0] wr_idx, rd_idx, rd_idx_nxt;
  logic [LW-1:0] level_nxt;

  afifo_ptr_ctl #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .clear(clear),
    .push_valid(push_valid), .pop_ready(pop_ready),
    .push_ready(push_ready), .pop_valid(pop_valid),
    .push_fire(push_fire), .overflow(overflow),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .rd_idx_nxt(rd_idx_nxt),
    .level_nxt(level_nxt)
  );

  afifo_store #(.DW(DATA_W), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .we(push_fire), .waddr(wr_idx),
    .wdata(push_data), .raddr(rd_idx_nxt), .rdata(pop_data)
  );

  afifo_flag_gen #(.AW(AW), .CAPTURE(CAPTURE)) u_flags (
    .clk(clk), .rst(rst), .level_nxt(level_nxt),
    .af_thr(thr_cfg[AF_LSB +: AW]), .ae_thr(thr_cfg[AE_LSB +: AW]),
    .status(fifo_status), .avail_bytes(avail_bytes)
  );

  always_comb begin
    addr_word                 = '0;
    addr_word[WR_LSB +: FW]   = {1'b0, wr_idx};
    addr_word[RD_LSB +: FW]   = {1'b0, rd_idx};
  end
endmodule

// File: rtl/afifo_checker.sv
module afifo_checker #(
  parameter  int AW     = 9,
  parameter  int WORD_W = 32,
  localparam int FW     = AW + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              clear,
  input logic              push_valid,
  input logic              push_ready,
  input logic              pop_valid,
  input logic              overflow,
  input logic [WORD_W-1:0] addr_word,
  input logic [3:0]        fifo_status
);
  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($past(push_valid) && $past(fifo_status[0]) && !$past(clear)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (push_valid && fifo_status[0] && !clear) |=> $stable(addr_word[FW-1:0]));

  p_full_empty_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(fifo_status[0] && fifo_status[1]));

  p_ready_not_full_r4: assert property (@(posedge clk) disable iff (rst)
    (!clear && !fifo_status[0]) |-> push_ready);

  p_clear_empties_r10: assert property (@(posedge clk) disable iff (rst)
    clear |=> (addr_word == '0) && fifo_status[1] && !pop_valid);

  p_valid_vs_empty_r12: assert property (@(posedge clk) disable iff (rst)
    pop_valid != fifo_status[1]);
endmodule

bind audio_sample_fifo afifo_checker #(.AW(AW), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .clear(clear), .push_valid(push_valid),
  .push_ready(push_ready), .pop_valid(pop_valid), .overflow(overflow),
  .addr_word(addr_word), .fifo_status(fifo_status)
);

// File: tb/sim_audio_sample_fifo.sv
module sim_audio_sample_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  // capture instance
  logic        c_clear = 0, c_pv = 0, c_pr = 0, c_rdy, c_vld, c_ovf;
  logic [31:0] c_pd = 0, c_od, c_addr, thr;
  logic [3:0]  c_st;
  logic [11:0] c_av;
  // playback instance
  logic        p_pv = 0, p_pr = 0, p_rdy, p_vld, p_ovf;
  logic [31:0] p_pd = 0, p_od, p_addr;
  logic [3:0]  p_st;
  logic [11:0] p_av;

  audio_sample_fifo #(.CAPTURE(1'b1)) u0 (
    .clk(clk), .rst(rst), .clear(c_clear), .thr_cfg(thr),
    .push_valid(c_pv), .push_ready(c_rdy), .push_data(c_pd),
    .pop_valid(c_vld), .pop_ready(c_pr), .pop_data(c_od),
    .addr_word(c_addr), .fifo_status(c_st), .avail_bytes(c_av), .overflow(c_ovf));

  audio_sample_fifo #(.CAPTURE(1'b0)) u1 (
    .clk(clk), .rst(rst), .clear(1'b0), .thr_cfg(thr),
    .push_valid(p_pv), .push_ready(p_rdy), .push_data(p_pd),
    .pop_valid(p_vld), .pop_ready(p_pr), .pop_data(p_od),
    .addr_word(p_addr), .fifo_status(p_st), .avail_bytes(p_av), .overflow(p_ovf));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int af_t = 8, ae_t = 4;
  int mw = 0, mr = 0, pw = 0, pr = 0;
  logic [31:0] mq[$];
  logic [31:0] pq[$];

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_st(input int lvl);
    return {lvl <= ae_t, lvl >= af_t, lvl == 0, lvl == 512};
  endfunction

  function automatic int cap_av(input int w, input int r, input int n);
    if (n == 512) return 2048;
    return (w >= r) ? 4 * (w - r) : 4 * (512 - r + w);
  endfunction

  function automatic int pb_av(input int w, input int r, input int n);
    if (n == 512) return 0;
    return (w >= r) ? 4 * (512 - w + r) : 4 * (r - w);
  endfunction

  function automatic logic [31:0] set_thr(input int af, input int ae);
    return (32'(ae) << 16) | 32'(af);
  endfunction

  task automatic c_state(input string req);
    chk(req, "addr_word", c_addr, (32'(mr) << 16) | 32'(mw));
    chk(req, "avail", 32'(c_av), 32'(cap_av(mw, mr, mq.size())));
    chk(req, "status", 32'(c_st), 32'(exp_st(mq.size())));
  endtask

  task automatic c_push(input logic [31:0] d);
    c_pv = 1; c_pd = d; tick(); c_pv = 0;
    if (mq.size() < 512) begin mq.push_back(d); mw = (mw + 1) % 512; end
  endtask

  task automatic c_pop(input string req);
    chk(req, "pop_valid", 32'(c_vld), 32'd1);
    chk(req, "pop_data", c_od, mq[0]);
    c_pr = 1; tick(); c_pr = 0;
    void'(mq.pop_front()); mr = (mr + 1) % 512;
  endtask

  task automatic t_reset();
    chk("R1", "cap addr", c_addr, 32'd0);
    chk("R1", "cap status", 32'(c_st), 32'b1010);
    chk("R1", "cap avail", 32'(c_av), 32'd0);
    chk("R1", "cap valid/ready", {30'd0, c_vld, c_rdy}, 32'b01);
    chk("R1", "pb avail", 32'(p_av), 32'd2048);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) c_push(32'hA000_0000 + 32'(i));
    c_state("R7");
    c_pop("R2"); c_pop("R2");
    c_state("R8");
    // simultaneous push and pop at level 3 (R11)
    chk("R11", "head before", c_od, mq[0]);
    c_pv = 1; c_pd = 32'hB00C_0001; c_pr = 1; tick(); c_pv = 0; c_pr = 0;
    void'(mq.pop_front()); mr++; mq.push_back(32'hB00C_0001); mw++;
    c_state("R11");
  endtask

  task automatic t_thresholds();
    while (mq.size() < 8) begin
      c_push(32'hC000_0000 + 32'(mq.size()));
      chk(mq.size() >= 8 ? "R5" : "R6", "status at level", 32'(c_st), 32'(exp_st(mq.size())));
    end
    af_t = 20; thr = set_thr(af_t, ae_t); tick();
    chk("R5", "af raised", 32'(c_st), 32'(exp_st(8)));
    af_t = 8; ae_t = 10; thr = set_thr(af_t, ae_t); tick();
    chk("R6", "ae raised", 32'(c_st), 32'b1100);
    ae_t = 4; thr = set_thr(af_t, ae_t); tick();
    chk("R5", "restored", 32'(c_st), 32'b0100);
  endtask

  task automatic t_clear();
    c_clear = 1; c_pv = 1; c_pd = 32'hDEAD_BEEF; c_pr = 1; tick();
    c_clear = 0; c_pv = 0; c_pr = 0;
    mq.delete(); mw = 0; mr = 0;
    c_state("R10");
    chk("R10", "pop_valid", 32'(c_vld), 32'd0);
    c_push(32'h0000_0055);
    c_pop("R10");
  endtask

  task automatic t_empty_pop();
    c_pr = 1; tick(); c_pr = 0;
    chk("R12", "pop_valid", 32'(c_vld), 32'd0);
    c_state("R12");
  endtask

  task automatic t_full();
    while (mq.size() < 512) c_push(32'h1000_0000 + 32'(mq.size()));
    c_state("R4");
    chk("R4", "push_ready full", 32'(c_rdy), 32'd0);
    c_pv = 1; c_pd = 32'hBAD0_BAD0; tick();
    chk("R3", "overflow pulse", 32'(c_ovf), 32'd1);
    c_pv = 0; tick();
    chk("R3", "overflow cleared", 32'(c_ovf), 32'd0);
    c_state("R3");
    while (mq.size() > 0) c_pop("R3");
    c_state("R4");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 505; i++) c_push(32'(i));
    while (mq.size() > 0) c_pop("R2");
    for (int i = 0; i < 20; i++) c_push(32'h2000_0000 + 32'(i));
    c_state("R8");
    chk("R8", "wrap avail", 32'(c_av), 32'd80);
    while (mq.size() > 0) c_pop("R2");
  endtask

  task automatic p_push(input logic [31:0] d);
    p_pv = 1; p_pd = d; tick(); p_pv = 0;
    if (pq.size() < 512) begin pq.push_back(d); pw = (pw + 1) % 512; end
  endtask

  task automatic p_pop();
    chk("R9", "pb data", p_od, pq[0]);
    p_pr = 1; tick(); p_pr = 0;
    void'(pq.pop_front()); pr = (pr + 1) % 512;
  endtask

  task automatic t_playback();
    for (int i = 0; i < 3; i++) p_push(32'h3000_0000 + 32'(i));
    chk("R9", "avail w>=r", 32'(p_av), 32'(pb_av(pw, pr, pq.size())));
    p_pop();
    chk("R9", "avail after pop", 32'(p_av), 32'd2040);
    while (pq.size() < 512) p_push(32'h4000_0000 + 32'(pq.size()));
    chk("R9", "avail full", 32'(p_av), 32'd0);
    chk("R9", "pb full flag", 32'(p_st[0]), 32'd1);
    p_pop(); p_pop();
    chk("R9", "avail w<r", 32'(p_av), 32'(pb_av(pw, pr, pq.size())));
    chk("R9", "avail w<r value", 32'(p_av), 32'd8);
  endtask

  initial begin
    thr = set_thr(af_t, ae_t);
    repeat (3) tick();
    rst = 0;
    t_reset();
    t_order();
    t_thresholds();
    t_clear();
    t_empty_pop();
    t_full();
    t_wrap();
    t_playback();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule